// File: doc/BRIEF.md
# MSI Summary Interrupt Wrapper with Zero-Read Re-arm

This block sits between a PCIe-style core and a CPU interrupt controller. It keeps a bank of per-vector MSI pending bits, each set by a one-cycle pulse from the core. It folds those bits into a single MSI summary bit in a small wrapper status register, and the same register also records rising edges on four legacy INTx lines. One level-sensitive interrupt line goes to the CPU. It is the OR of the wrapper status bits, each gated by its own enable bit.

The summary bit is not a live OR of the pending vectors. Once it has latched, the MSI path is disarmed. Clearing the summary bit does not re-arm it, and neither do pending vectors. The path re-arms only when software reads the vector bank and the read returns all zeros. The next vector pulse after that sets the summary bit again. A vector pulse that arrives in the same cycle as the zero-returning read also latches, so no event is lost across the re-arm.

Software uses a single-cycle register bus. A read returns data combinationally in the cycle it is presented. A write clears every status bit written as 1 and loads the enable register. The usual handler reads the wrapper status, writes the same value back, then reads and clears the vector bank until it reads zero.

Top module: `irq_fold_wrap`

## Requirements
- R1: After reset the wrapper status, the vector bank and the enable register all read 0, irq_out is low, and the MSI path is armed.
- R2: A pulse on vec_pulse[i] sets vector bit i, which holds until a write to address 1 with bit i set to 1; bits written as 0 are kept, and no vector bit sets without a pulse.
- R3: When a set event (vector pulse or legacy rising edge) and a write-1-to-clear hit the same bit in the same cycle, the bit ends at 1.
- R4: While the MSI path is armed, any vector pulse sets wrapper status bit 4 on the next clock edge and disarms the path.
- R5: While disarmed, vector pulses do not set bit 4, even after bit 4 has been cleared and while vectors are pending.
- R6: A read of address 1 (vector bank) that returns 0 re-arms the MSI path from the next cycle, so a later vector pulse sets bit 4 again.
- R7: A vector pulse in the same cycle as a read of address 1 that returns 0 still sets bit 4.
- R8: A read of address 1 that returns a nonzero value does not re-arm the MSI path.
- R9: Wrapper status bits 0 to 3 (INTA, INTB, INTC, INTD) set on a rising level of intx[0..3]. A line held high does not set its bit again after it is cleared. These bits ignore the MSI arm state.
- R10: A write to address 0 clears each wrapper status bit written as 1 and leaves the others unchanged.
- R11: irq_out is high exactly when some wrapper status bit and the matching bit of the enable register (address 2, bits 4:0) are both 1.
- R12: Reads decode address 0 as wrapper status (bits 4:0), 1 as the vector bank and 2 as the enable register. Address 3 and cycles with no read return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_pulse | input | NVEC | One-cycle per-vector MSI set pulses |
| intx | input | 4 | Legacy interrupt levels A to D |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data (1 bits clear status) |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_out | output | 1 | Level interrupt to the CPU |

## Verification
The assertions check on every cycle that vector bits never appear without a pulse and always take their pulse, and that the summary bit latches when armed. They also check that it cannot rise while disarmed without a zero read, that a clean zero read leaves the path armed, and that a zero read coinciding with a pulse still latches. Some properties need sequences of bus operations that no single-cycle property captures, and only the bench scenarios show them. These are clearing the summary bit and then pulsing without re-arming, a nonzero read failing to re-arm, a legacy line held high across a clear, and the enable mask. The bench model tracks the arm state behaviourally and compares read data and the interrupt line on every cycle.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int LEG_N   = 4;
    localparam int WS_W    = LEG_N + 1;
    localparam int MSI_POS = LEG_N;

    typedef enum logic [ADDR_W-1:0] {
        A_WSTAT  = 2'd0,
        A_VSTAT  = 2'd1,
        A_ENABLE = 2'd2,
        A_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // next value of a write-1-to-clear bit: a set event beats a clear
    function automatic logic w1c_bit(input logic cur, input logic clr, input logic set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/irq_vec_bank.sv
module irq_vec_bank
    import irq_fold_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NVEC-1:0] set_i,
    input  logic [NVEC-1:0] clr_i,
    output logic [NVEC-1:0] vec_o
);

    logic [NVEC-1:0] vec_q;

    for (genvar i = 0; i < NVEC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) vec_q[i] <= 1'b0;
            else     vec_q[i] <= w1c_bit(vec_q[i], clr_i[i], set_i[i]);
        end
    end

    assign vec_o = vec_q;

    // every pulsed bit is 1 on the following edge, clear or not
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((vec_q & $past(set_i)) == $past(set_i)));

    // no vector bit rises without its own pulse
    assert_no_phantom_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((vec_q & ~$past(vec_q) & ~$past(set_i)) == '0));

endmodule

// File: rtl/irq_wrap_stat.sv
module irq_wrap_stat
    import irq_fold_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LEG_N-1:0] intx_i,
    input  logic             any_vec_i,
    input  logic             zero_rd_i,
    input  logic [WS_W-1:0]  clr_i,
    output logic [WS_W-1:0]  stat_o
);

    logic [WS_W-1:0]  stat_q;
    logic [LEG_N-1:0] intx_prev_q;
    logic [LEG_N-1:0] intx_rise;
    logic             armed_q;
    logic             msi_hit;

    assign intx_rise = intx_i & ~intx_prev_q;
    // the zero read arms this very cycle for a pulse that arrives with it
    assign msi_hit   = any_vec_i & (armed_q | zero_rd_i);

    always_ff @(posedge clk) begin
        if (rst) intx_prev_q <= '0;
        else     intx_prev_q <= intx_i;
    end

    for (genvar k = 0; k < LEG_N; k++) begin : g_leg
        always_ff @(posedge clk) begin
            if (rst) stat_q[k] <= 1'b0;
            else     stat_q[k] <= w1c_bit(stat_q[k], clr_i[k], intx_rise[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q[MSI_POS] <= 1'b0;
            armed_q         <= 1'b1;
        end else begin
            stat_q[MSI_POS] <= w1c_bit(stat_q[MSI_POS], clr_i[MSI_POS], msi_hit);
            if (msi_hit)        armed_q <= 1'b0;
            else if (zero_rd_i) armed_q <= 1'b1;
        end
    end

    assign stat_o = stat_q;

    assert_latch_R4: assert property (@(posedge clk) disable iff (rst)
        (any_vec_i && armed_q) |=> stat_q[MSI_POS]);

    assert_no_relatch_R5: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !zero_rd_i && !stat_q[MSI_POS]) |=> !stat_q[MSI_POS]);

    assert_rearm_R6: assert property (@(posedge clk) disable iff (rst)
        (zero_rd_i && !any_vec_i) |=> armed_q);

    assert_same_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        (zero_rd_i && any_vec_i) |=> stat_q[MSI_POS]);

    assert_leg_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (|intx_rise) |=> ((stat_q[LEG_N-1:0] & $past(intx_rise)) == $past(intx_rise)));

endmodule

// File: rtl/irq_fold_wrap.sv
module irq_fold_wrap
    import irq_fold_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NVEC-1:0]   vec_pulse,
    input  logic [LEG_N-1:0]  intx,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    bus_req_t        req;
    logic            rd_en;
    logic            wr_ws, wr_vs, wr_en;
    logic [NVEC-1:0] vec_q;
    logic [WS_W-1:0] ws_q;
    logic [WS_W-1:0] en_q;
    logic            zero_rd;

    assign req = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    assign rd_en   = req.sel & ~req.wr;
    assign wr_ws   = req.sel & req.wr & (req.addr == A_WSTAT);
    assign wr_vs   = req.sel & req.wr & (req.addr == A_VSTAT);
    assign wr_en   = req.sel & req.wr & (req.addr == A_ENABLE);
    assign zero_rd = rd_en & (req.addr == A_VSTAT) & (vec_q == '0);

    irq_vec_bank #(.NVEC(NVEC)) u_vec (
        .clk   (clk),
        .rst   (rst),
        .set_i (vec_pulse),
        .clr_i (wr_vs ? req.wdata[NVEC-1:0] : '0),
        .vec_o (vec_q)
    );

    irq_wrap_stat u_ws (
        .clk       (clk),
        .rst       (rst),
        .intx_i    (intx),
        .any_vec_i (|vec_pulse),
        .zero_rd_i (zero_rd),
        .clr_i     (wr_ws ? req.wdata[WS_W-1:0] : '0),
        .stat_o    (ws_q)
    );

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (wr_en) en_q <= req.wdata[WS_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (req.addr)
                A_WSTAT:  bus_rdata = DATA_W'(ws_q);
                A_VSTAT:  bus_rdata = DATA_W'(vec_q);
                A_ENABLE: bus_rdata = DATA_W'(en_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq_out = |(ws_q & en_q);

    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_out);

    assert_idle_bus_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> (bus_rdata == '0));

endmodule

// File: tb/sim_irq_fold_wrap.sv
`timescale 1ns/1ps
module sim_irq_fold_wrap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] vec_pulse = '0;
    logic [3:0]  intx = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    always #2 clk = ~clk;

    irq_fold_wrap #(.NVEC(32)) u0 (
        .clk(clk), .rst(rst), .vec_pulse(vec_pulse), .intx(intx),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    int errs = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_vec = '0;
    logic [4:0]  m_ws = '0;
    logic [4:0]  m_en = '0;
    bit          m_armed = 1;
    logic [3:0]  m_prev = '0;

    logic [31:0] last_rd;
    logic        last_irq;
    logic [3:0]  ix = '0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [31:0] vp, input logic s, input logic w,
                       input logic [1:0] a, input logic [31:0] d, input string tag);
        logic [31:0] erd;
        bit zero, hit;
        logic [3:0] rise;
        @(negedge clk);
        vec_pulse = vp; intx = ix; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        erd = '0;
        if (s && !w) begin
            if (a == 2'd0)      erd = {27'd0, m_ws};
            else if (a == 2'd1) erd = m_vec;
            else if (a == 2'd2) erd = {27'd0, m_en};
        end
        last_rd = bus_rdata;
        last_irq = irq_out;
        chk(bus_rdata, erd, {tag, " rdata model"});
        chk({31'd0, irq_out}, {31'd0, |(m_ws & m_en)}, {tag, " irq model"});
        @(posedge clk);
        zero = s && !w && a == 2'd1 && m_vec == 0;
        hit = (vp != 0) && (m_armed || zero);
        rise = ix & ~m_prev;
        m_ws[3:0] = (m_ws[3:0] & ~((s && w && a == 2'd0) ? d[3:0] : 4'h0)) | rise;
        m_ws[4] = (m_ws[4] & ~((s && w && a == 2'd0) ? d[4] : 1'b0)) | hit;
        if (hit) m_armed = 0;
        else if (zero) m_armed = 1;
        m_vec = (m_vec & ~((s && w && a == 2'd1) ? d : 32'h0)) | vp;
        if (s && w && a == 2'd2) m_en = d[4:0];
        m_prev = ix;
    endtask

    task automatic idle(input string tag);
        cyc(32'h0, 0, 0, 2'd0, 32'h0, tag);
    endtask
    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        cyc(32'h0, 1, 1, a, d, tag);
    endtask
    task automatic rd_expect(input logic [1:0] a, input logic [31:0] e, input string tag);
        cyc(32'h0, 1, 0, a, 32'h0, tag);
        chk(last_rd, e, tag);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd_expect(2'd0, 32'h0, "R1 wstat");
        rd_expect(2'd1, 32'h0, "R1 vstat");
        rd_expect(2'd2, 32'h0, "R1 enable");
        chk({31'd0, last_irq}, 32'h0, "R1 irq");

        // R11 enable all, R4 first vector latches summary
        wr(2'd2, 32'h1F, "R11");
        cyc(32'h8, 0, 0, 2'd0, 32'h0, "R4");
        rd_expect(2'd0, 32'h10, "R4 summary");
        chk({31'd0, last_irq}, 32'h1, "R4 irq");
        rd_expect(2'd1, 32'h8, "R2 vector bit");

        // R10 clear summary, R5 no relatch while disarmed
        wr(2'd0, 32'h10, "R10");
        idle("R10");
        chk({31'd0, last_irq}, 32'h0, "R10 irq low");
        cyc(32'h80, 0, 0, 2'd0, 32'h0, "R5");
        rd_expect(2'd0, 32'h0, "R5 no relatch");

        // R8 nonzero read does not re-arm
        rd_expect(2'd1, 32'h88, "R8 read");
        cyc(32'h200, 0, 0, 2'd0, 32'h0, "R8");
        rd_expect(2'd0, 32'h0, "R8 still disarmed");

        // R3 set beats clear on vector bank
        cyc(32'h4, 1, 1, 2'd1, 32'hFFFF_FFFF, "R3");
        rd_expect(2'd1, 32'h4, "R3 vector set wins");

        // R2 partial clear keeps 0-written bits
        cyc(32'h3, 0, 0, 2'd0, 32'h0, "R2");
        wr(2'd1, 32'h1, "R2");
        rd_expect(2'd1, 32'h6, "R2 partial clear");
        wr(2'd1, 32'h6, "R2");

        // R6 zero read re-arms
        rd_expect(2'd1, 32'h0, "R6 zero read");
        cyc(32'h1, 0, 0, 2'd0, 32'h0, "R6");
        rd_expect(2'd0, 32'h10, "R6 relatch");
        chk({31'd0, last_irq}, 32'h1, "R6 irq");

        // R7 pulse coinciding with zero read
        wr(2'd0, 32'h10, "R7");
        wr(2'd1, 32'h1, "R7");
        cyc(32'h20, 1, 0, 2'd1, 32'h0, "R7");
        chk(last_rd, 32'h0, "R7 read was zero");
        rd_expect(2'd0, 32'h10, "R7 latched");
        rd_expect(2'd1, 32'h20, "R7 vector");
        wr(2'd0, 32'h10, "R7");
        wr(2'd1, 32'h20, "R7");

        // R9 legacy edges
        ix = 4'b0010;
        idle("R9");
        rd_expect(2'd0, 32'h2, "R9 INTB latched");
        wr(2'd0, 32'h2, "R9");
        idle("R9");
        rd_expect(2'd0, 32'h0, "R9 held level no relatch");
        ix = 4'b0000;
        idle("R9");
        ix = 4'b0100;
        idle("R9");
        rd_expect(2'd0, 32'h4, "R9 INTC while disarmed");

        // R3 set beats clear on legacy bit
        wr(2'd0, 32'h4, "R3");
        ix = 4'b0000;
        idle("R3");
        ix = 4'b0100;
        wr(2'd0, 32'h4, "R3");
        rd_expect(2'd0, 32'h4, "R3 legacy set wins");

        // R11 mask
        wr(2'd2, 32'h10, "R11");
        idle("R11");
        chk({31'd0, last_irq}, 32'h0, "R11 masked");
        wr(2'd2, 32'h04, "R11");
        idle("R11");
        chk({31'd0, last_irq}, 32'h1, "R11 unmasked");

        // R12 decode
        rd_expect(2'd3, 32'h0, "R12 spare address");
        idle("R12");
        chk(last_rd, 32'h0, "R12 no read");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule